// File: doc/BRIEF.md
# Serial Command Frame Timeout Supervisor

This block watches the serial command port of a sensor converter and clears the command shifter when a host starts a command but leaves it unfinished. The serial clock and the active-low chip select are brought into the system clock domain through a two-stage synchronizer. The block then looks for serial clock edges and keeps track of whether a command frame is open. While a frame is open it counts modulator-rate ticks. If the count reaches the limit for the current speed mode before a whole command byte has arrived, it issues a single-cycle reset to the shifter.

The port runs in SPI mode 1. The serial clock idles low, data changes on its rising edge and is captured on its falling edge. A frame opens on a rising serial clock edge and closes once the configured number of falling edges has been seen. One tick arrives per modulator period. The modulator runs twice as fast in turbo mode, so the turbo limit is twice the normal limit and both limits cover the same wall time. After a timeout the block waits for the next rising serial clock edge, which opens a fresh frame with all counts at zero.

Top module: `cmd_frame_watchdog`

## Requirements
- R1: After reset, `frame_active` and `if_rst_pulse` are both 0.
- R2: `sclk` and `cs_n` each pass two synchronizer flops. A rising `sclk` while the synchronized `cs_n` is low and no frame is open sets `frame_active` on the third rising `clk` edge after the input changed.
- R3: A frame opens only on a rising `sclk` edge while `cs_n` is low and no frame is open. A falling `sclk` edge while idle has no effect.
- R4: A frame closes normally on its FRAME_BITS-th falling `sclk` edge (8 by default). `frame_active` then drops, no reset pulse is issued, and both counters return to zero.
- R5: With `turbo_mode` = 0, a timeout is declared when NORMAL_LIMIT ticks have been counted in an open frame. The tick on the edge that opens the frame is not counted. On a timeout, `if_rst_pulse` is high for exactly one `clk` cycle and `frame_active` falls in that same cycle.
- R6: With `turbo_mode` = 1, the limit is TURBO_LIMIT ticks instead.
- R7: While the synchronized `cs_n` is high, the tick count is held at zero, `frame_active` is 0 and no reset pulse is issued, however many ticks arrive. Raising `cs_n` during a frame abandons that frame without a pulse.
- R8: After a timeout, the next rising `sclk` edge opens a fresh frame with both its bit count and its tick count starting from zero.
- R9: If the closing falling edge and the limit-reaching tick land in the same cycle, completion wins and no reset pulse is issued.
- R10: Ticks that arrive while no frame is open, with `cs_n` low, are not counted and cause no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host (asynchronous) |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| turbo_mode | input | 1 | 0 = normal or duty-cycle limit, 1 = turbo limit |
| mod_tick | input | 1 | One-cycle pulse per modulator period |
| if_rst_pulse | output | 1 | One-cycle reset to the command shifter on timeout |
| frame_active | output | 1 | High while a command frame is open |

## Verification
The hardest case to reach is R9, where the last falling serial clock edge and the tick that reaches the limit are seen on the same system clock edge. Free-running ticks almost never line these up. For this case the bench switches to hand-placed ticks. It feeds exactly one tick less than the limit during an open frame, and then places the final tick two clocks after the last `sclk` fall is driven, because the synchronizer and the edge register delay that fall by this much. A behavioural model runs every cycle next to the design, so the timing of the synchronizer, of frame start and of every pulse is compared on every clock.

// File: rtl/cfw_pkg.sv
package cfw_pkg;
  typedef enum logic {
    SPD_NORMAL = 1'b0,
    SPD_TURBO  = 1'b1
  } speed_e;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_START,
    EV_DONE,
    EV_TIMEOUT,
    EV_ABORT
  } frame_ev_e;

  function automatic int unsigned larger(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cfw_sync.sv
module cfw_sync #(
  parameter int unsigned     WIDTH   = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stg <= {STAGES{RST_VAL}};
        else     stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfw_edge.sv
module cfw_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk_s,
  input  logic cs_n_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_idle
);
  logic sclk_d;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_idle   = cs_n_s;
endmodule

// File: rtl/cfw_tracker.sv
module cfw_tracker
  import cfw_pkg::*;
#(
  parameter int unsigned NORMAL_LIMIT = 13955,
  parameter int unsigned TURBO_LIMIT  = 27910,
  parameter int unsigned FRAME_BITS   = 8
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   sclk_rise,
  input  logic   sclk_fall,
  input  logic   cs_idle,
  input  speed_e speed,
  input  logic   mod_tick,
  output logic   frame_active,
  output logic   if_rst_pulse
);
  localparam int unsigned MAX_LIMIT = larger(NORMAL_LIMIT, TURBO_LIMIT);
  localparam int unsigned CNT_W     = $clog2(MAX_LIMIT + 1);
  localparam int unsigned BIT_W     = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] NORM_M1  = CNT_W'(NORMAL_LIMIT - 1);
  localparam logic [CNT_W-1:0] TURBO_M1 = CNT_W'(TURBO_LIMIT - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0] tick_cnt;
  logic [BIT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] lim_m1;
  logic             last_fall;
  logic             expire;
  frame_ev_e        ev;

  assign lim_m1    = (speed == SPD_TURBO) ? TURBO_M1 : NORM_M1;
  assign last_fall = sclk_fall && (bit_cnt == LAST_BIT);
  assign expire    = mod_tick && (tick_cnt >= lim_m1);

  always_comb begin
    ev = EV_NONE;
    if (cs_idle) begin
      ev = EV_ABORT;
    end else if (frame_active) begin
      if (last_fall)   ev = EV_DONE;
      else if (expire) ev = EV_TIMEOUT;
    end else if (sclk_rise) begin
      ev = EV_START;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_active <= 1'b0;
      if_rst_pulse <= 1'b0;
      tick_cnt     <= '0;
      bit_cnt      <= '0;
    end else begin
      if_rst_pulse <= 1'b0;
      case (ev)
        EV_START: begin
          frame_active <= 1'b1;
          tick_cnt     <= '0;
          bit_cnt      <= '0;
        end
        EV_DONE, EV_ABORT: begin
          frame_active <= 1'b0;
          tick_cnt     <= '0;
          bit_cnt      <= '0;
        end
        EV_TIMEOUT: begin
          frame_active <= 1'b0;
          if_rst_pulse <= 1'b1;
          tick_cnt     <= '0;
          bit_cnt      <= '0;
        end
        default: begin
          if (frame_active) begin
            if (mod_tick)  tick_cnt <= tick_cnt + 1'b1;
            if (sclk_fall) bit_cnt  <= bit_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R5: reset pulse lasts one cycle only
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (rst)
    if_rst_pulse |=> !if_rst_pulse);

  // R5: frame flag falls in the pulse cycle
  a_r5_active_falls: assert property (@(posedge clk) disable iff (rst)
    if_rst_pulse |-> (!frame_active && $past(frame_active)));

  // R7: deselected port holds everything quiet
  a_r7_hold_zero: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> (tick_cnt == '0) && !frame_active && !if_rst_pulse);

  // R3: a frame opens only after a rising serial edge while selected
  a_r3_start: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_active) |-> $past(sclk_rise && !cs_idle));

  // R9: closing edge always beats a coincident expiry
  a_r9_done_wins: assert property (@(posedge clk) disable iff (rst)
    (frame_active && !cs_idle && sclk_fall && (bit_cnt == LAST_BIT)) |=> (!if_rst_pulse && !frame_active));
endmodule

// File: rtl/cmd_frame_watchdog.sv
module cmd_frame_watchdog
  import cfw_pkg::*;
#(
  parameter int unsigned NORMAL_LIMIT = 13955,
  parameter int unsigned TURBO_LIMIT  = 27910,
  parameter int unsigned FRAME_BITS   = 8,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic turbo_mode,
  input  logic mod_tick,
  output logic if_rst_pulse,
  output logic frame_active
);
  logic [1:0] raw_pins;
  logic [1:0] sync_pins;
  logic       sclk_rise;
  logic       sclk_fall;
  logic       cs_idle;
  speed_e     speed;

  assign raw_pins = {cs_n, sclk};
  assign speed    = turbo_mode ? SPD_TURBO : SPD_NORMAL;

  cfw_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b10)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (raw_pins),
    .q  (sync_pins)
  );

  cfw_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (sync_pins[0]),
    .cs_n_s   (sync_pins[1]),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .cs_idle  (cs_idle)
  );

  cfw_tracker #(
    .NORMAL_LIMIT(NORMAL_LIMIT),
    .TURBO_LIMIT (TURBO_LIMIT),
    .FRAME_BITS  (FRAME_BITS)
  ) u_tracker (
    .clk         (clk),
    .rst         (rst),
    .sclk_rise   (sclk_rise),
    .sclk_fall   (sclk_fall),
    .cs_idle     (cs_idle),
    .speed       (speed),
    .mod_tick    (mod_tick),
    .frame_active(frame_active),
    .if_rst_pulse(if_rst_pulse)
  );
endmodule

// File: tb/cmd_frame_watchdog_tb.sv
module cmd_frame_watchdog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 30;
  localparam int TL = 60;
  localparam int FB = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic turbo_mode = 1'b0;
  logic mod_tick = 1'b0;
  logic if_rst_pulse;
  logic frame_active;

  int vectors = 0;
  int miscompares = 0;
  int pulse_total = 0;
  int act_ticks = 0;
  int tick_ctr = 0;
  bit auto_tick = 1'b1;
  bit started = 1'b0;
  bit finished = 1'b0;

  // behavioural reference state
  bit m_active, m_pulse;
  int m_cnt, m_bits;
  bit sh[3];
  bit ch[3];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_frame_watchdog #(.NORMAL_LIMIT(NL), .TURBO_LIMIT(TL), .FRAME_BITS(FB), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .turbo_mode(turbo_mode),
    .mod_tick(mod_tick), .if_rst_pulse(if_rst_pulse), .frame_active(frame_active));

  always @(posedge clk) begin
    bit r, f, idle;
    int lim;
    if (rst) begin
      m_active = 0; m_pulse = 0; m_cnt = 0; m_bits = 0;
      sh = '{0, 0, 0};
      ch = '{1, 1, 1};
    end else begin
      r = sh[1] && !sh[2];
      f = !sh[1] && sh[2];
      idle = ch[1];
      lim = turbo_mode ? TL : NL;
      m_pulse = 0;
      if (idle) begin
        m_active = 0; m_cnt = 0; m_bits = 0;
      end else if (m_active) begin
        if (f && m_bits + 1 == FB) begin
          m_active = 0; m_cnt = 0; m_bits = 0;
        end else if (mod_tick && m_cnt + 1 >= lim) begin
          m_active = 0; m_cnt = 0; m_bits = 0; m_pulse = 1;
        end else begin
          m_cnt += int'(mod_tick);
          m_bits += int'(f);
        end
      end else if (r) begin
        m_active = 1; m_cnt = 0; m_bits = 0;
      end
      sh[2] = sh[1]; sh[1] = sh[0]; sh[0] = sclk;
      ch[2] = ch[1]; ch[1] = ch[0]; ch[0] = cs_n;
    end
    started = 1'b1;
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      vectors++;
      if (frame_active !== m_active) begin
        miscompares++;
        $display("FAIL R3 per-cycle frame_active actual=%0b expected=%0b t=%0t", frame_active, m_active, $time);
      end
      vectors++;
      if (if_rst_pulse !== m_pulse) begin
        miscompares++;
        $display("FAIL R5 per-cycle if_rst_pulse actual=%0b expected=%0b t=%0t", if_rst_pulse, m_pulse, $time);
      end
      if (if_rst_pulse === 1'b1) pulse_total++;
    end
  end

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic step();
    @(negedge clk);
    tick_ctr++;
    if (auto_tick) mod_tick = ((tick_ctr % (turbo_mode ? 2 : 4)) == 0);
    else           mod_tick = 1'b0;
    if (frame_active && mod_tick) act_ticks++;
  endtask

  task automatic pulse_sclk();
    step(); sclk = 1'b1;
    repeat (3) step();
    sclk = 1'b0;
    repeat (2) step();
  endtask

  task automatic wait_pulse(output bit seen);
    seen = 0;
    for (int i = 0; i < 1000; i++) begin
      step();
      if (if_rst_pulse) begin seen = 1; break; end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int p0;
    bit seen;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1: reset state
    check(frame_active == 1'b0, "R1 frame_active after reset", frame_active, 0);
    check(if_rst_pulse == 1'b0, "R1 if_rst_pulse after reset", if_rst_pulse, 0);

    // R10: ticks while idle and selected
    cs_n = 1'b0;
    p0 = pulse_total;
    repeat (200) step();
    check(pulse_total == p0, "R10 pulses while idle", pulse_total - p0, 0);
    check(frame_active == 1'b0, "R10 idle frame_active", frame_active, 0);

    // R2: synchronizer latency of a rising sclk
    step(); sclk = 1'b1;
    step(); check(frame_active == 1'b0, "R2 edge1", frame_active, 0);
    step(); check(frame_active == 1'b0, "R2 edge2", frame_active, 0);
    step(); check(frame_active == 1'b1, "R2 edge3", frame_active, 1);
    step(); sclk = 1'b0;
    repeat (2) step();
    // R4: complete byte (first fall above counts as bit 1)
    p0 = pulse_total;
    repeat (FB - 2) pulse_sclk();
    repeat (3) step();
    check(frame_active == 1'b1, "R4 open before last bit", frame_active, 1);
    pulse_sclk();
    repeat (3) step();
    check(frame_active == 1'b0, "R4 closed after last bit", frame_active, 0);
    check(pulse_total == p0, "R4 no pulse on completion", pulse_total - p0, 0);

    // R5: normal timeout with partial frame
    act_ticks = 0;
    p0 = pulse_total;
    repeat (3) pulse_sclk();
    wait_pulse(seen);
    check(seen, "R5 timeout pulse seen", seen, 1);
    check(act_ticks == NL, "R5 ticks counted to timeout", act_ticks, NL);
    check(frame_active == 1'b0, "R5 frame_active with pulse", frame_active, 0);
    step();
    check(if_rst_pulse == 1'b0, "R5 pulse one cycle", if_rst_pulse, 0);
    check(pulse_total - p0 == 1, "R5 single pulse", pulse_total - p0, 1);

    // R8: fresh frame needs all FB falls
    p0 = pulse_total;
    repeat (FB - 1) pulse_sclk();
    repeat (3) step();
    check(frame_active == 1'b1, "R8 still open after FB-1 bits", frame_active, 1);
    pulse_sclk();
    repeat (3) step();
    check(frame_active == 1'b0, "R8 closed after FB bits", frame_active, 0);
    check(pulse_total == p0, "R8 no pulse", pulse_total - p0, 0);

    // R6: turbo limit
    turbo_mode = 1'b1;
    act_ticks = 0;
    pulse_sclk();
    wait_pulse(seen);
    check(seen, "R6 turbo pulse seen", seen, 1);
    check(act_ticks == TL, "R6 turbo ticks", act_ticks, TL);
    step();
    turbo_mode = 1'b0;

    // R7: deselect mid-frame, long hold
    repeat (2) pulse_sclk();
    p0 = pulse_total;
    cs_n = 1'b1;
    repeat (4) step();
    check(frame_active == 1'b0, "R7 abandoned frame", frame_active, 0);
    repeat (300) step();
    check(pulse_total == p0, "R7 no pulse while deselected", pulse_total - p0, 0);
    cs_n = 1'b0;
    repeat (4) step();
    act_ticks = 0;
    pulse_sclk();
    wait_pulse(seen);
    check(act_ticks == NL, "R7 count starts from zero", act_ticks, NL);

    // R9: completion coincides with expiry
    auto_tick = 1'b0;
    step(); sclk = 1'b1;
    repeat (4) step();
    check(frame_active == 1'b1, "R9 frame open", frame_active, 1);
    for (int i = 0; i < NL - 1; i++) begin
      step(); mod_tick = 1'b1;
    end
    step();
    step(); sclk = 1'b0;
    repeat (2) step();
    repeat (FB - 2) pulse_sclk();
    step(); sclk = 1'b1;
    repeat (3) step();
    p0 = pulse_total;
    sclk = 1'b0;
    step(); step(); mod_tick = 1'b1;
    repeat (3) step();
    check(pulse_total == p0, "R9 completion wins", pulse_total - p0, 0);
    check(frame_active == 1'b0, "R9 frame closed", frame_active, 0);
    auto_tick = 1'b1;
    repeat (5) step();
    finish_run();
  end
endmodule